// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches 16-bit words from a three-wire serial EEPROM. A host presents a word address with a one-cycle request. The block then runs a complete read on the device pins and returns the word with a one-cycle valid strobe. It raises chip select and gives one idle clock pulse. It then shifts out the read command and the address bits, and clocks in sixteen data bits. The serial clock is made from the system clock. Each half period lasts a programmable number of system cycles.

The number of address bits the EEPROM expects does not have to be known in advance. On the first access after reset, the block sends address bits one at a time and watches the device's data output after each one. The device pulls that line low (its dummy zero) once it has received its full address. The count of bits sent up to that point becomes the address width, and all later reads use it. If the line never goes low within the maximum width, the block uses the maximum width and raises a sticky error flag.

Top module: `sprom_word_reader`

## Requirements
- R1: After reset `busy`, `rd_valid`, `ee_cs`, `ee_sk` and `aw_err` are 0 and `addr_width` is 0 (meaning width not yet known). Whenever `busy` is 0, `ee_cs` and `ee_sk` are both low.
- R2: An accepted access raises `ee_cs` with `ee_sk` low. It then gives exactly one `ee_sk` pulse with `ee_di` low, followed by the read command 1,1,0, sent most significant bit first with the leading 1 acting as start bit. `ee_di` changes only while `ee_sk` is low.
- R3: Every low and every high half of `ee_sk` lasts max(`div_cnt`,1) system clock cycles, where `div_cnt` is taken when the request is accepted.
- R4: Once the width W is known, an access sends exactly W address bits, `rd_addr[W-1:0]`, most significant first, so each access has 20+W `ee_sk` pulses in total.
- R5: While the width is unknown, address bits are taken from `rd_addr[MAX_AW-1]` downward, and `ee_do` is sampled on the last system cycle of each address high half. The first low sample after the k-th bit ends the address phase and sets `addr_width` to k, which is MAX_AW minus the bits still unsent.
- R6: If no low sample appears within MAX_AW (8) address bits, `addr_width` becomes 8 and `aw_err` becomes 1 and stays 1 until reset.
- R7: A learned width is kept unchanged for all later accesses until reset.
- R8: Sixteen data bits are sampled most significant first, each on the last system cycle of an `ee_sk` high half. `rd_data` then shows the word in the same cycle that `rd_valid` pulses for one cycle and `busy` falls.
- R9: After the 16th data bit `ee_cs` drops with `ee_sk` low, and `busy` stays high for max(`div_cnt`,1) more cycles with the pins idle. `ee_sk` is never high while `ee_cs` is low.
- R10: `rd_req` asserted while `busy` is 1 is ignored. It does not change the current access and starts no further access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cnt | input | DIV_W | Serial clock half period in system cycles (0 acts as 1) |
| rd_req | input | 1 | Read request, taken when idle |
| rd_addr | input | MAX_AW | Word address |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` fresh |
| rd_data | output | DATA_W | Word read from the EEPROM |
| addr_width | output | AW_W | Learned address width, 0 while unknown |
| aw_err | output | 1 | Sticky flag: no dummy zero was seen during learning |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
On the last address bit of a learning access, two different width decisions meet on one edge. A low sample there fixes the width at the full 8 bits. A high sample there declares failure, which also gives 8 but sets the error flag. The bench provokes both by resetting and pairing one learning read with an 8-bit device model and another with a device that never drives its data line low. It judges the outcome from `addr_width`, `aw_err`, the pulse count on `ee_sk` and the returned word (all ones for the silent device).

// File: rtl/sprom_pkg.sv
package sprom_pkg;

    // Command bits as seen on the wire: start bit, then the two read opcode bits.
    localparam logic [2:0] READ_CMD = 3'b110;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEL,
        PH_CMD,
        PH_ADDR,
        PH_DATA,
        PH_REST
    } phase_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } pins_t;

    // Phases in which the serial clock toggles.
    function automatic logic phase_clocked(input phase_e p);
        return (p == PH_SEL) || (p == PH_CMD) || (p == PH_ADDR) || (p == PH_DATA);
    endfunction

    // Phases in which chip select is held high.
    function automatic logic phase_selected(input phase_e p);
        return (p != PH_IDLE) && (p != PH_REST);
    endfunction

endpackage

// File: rtl/sprom_halfper.sv
module sprom_halfper #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             run,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    // A zero divider behaves as one cycle per half period.
    assign last = (div_q == '0) ? '0 : div_q - DIV_W'(1);
    assign tick = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (load) begin
            div_q <= div_in;
            cnt   <= '0;
        end else if (run) begin
            if (tick) cnt <= '0;
            else      cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/sprom_width_track.sv
module sprom_width_track #(
    parameter int MAX_AW = 8,
    parameter int AW_W   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fix_en,
    input  logic [AW_W-1:0] fix_val,
    input  logic            fail,
    output logic [AW_W-1:0] width,
    output logic            known,
    output logic            err
);
    assign known = (width != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            width <= '0;
            err   <= 1'b0;
        end else if (!known) begin
            if (fix_en) begin
                width <= fix_val;
            end else if (fail) begin
                width <= AW_W'(MAX_AW);
                err   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sprom_seq.sv
module sprom_seq
    import sprom_pkg::*;
#(
    parameter int MAX_AW = 8,
    parameter int DATA_W = 16,
    parameter int AW_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [MAX_AW-1:0] addr,
    input  logic              tick,
    input  logic              known,
    input  logic [AW_W-1:0]   width,
    input  logic              ee_do,
    output logic              start,
    output logic              busy,
    output pins_t             pins,
    output logic              fix_en,
    output logic [AW_W-1:0]   fix_val,
    output logic              fail,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    localparam int SPAN   = (DATA_W > MAX_AW) ? DATA_W : MAX_AW;
    localparam int IDX_W  = $clog2(SPAN);
    localparam int AIDX_W = (MAX_AW > 1) ? $clog2(MAX_AW) : 1;

    phase_e             phase;
    logic               hi;
    logic [IDX_W-1:0]   idx;
    logic [MAX_AW-1:0]  addr_q;
    logic [DATA_W-1:0]  shreg;
    logic               end_hi;
    logic               learn_hit;

    assign start     = (phase == PH_IDLE) && req;
    assign busy      = (phase != PH_IDLE);
    assign end_hi    = tick && hi;
    assign learn_hit = (phase == PH_ADDR) && end_hi && !known && !ee_do;

    assign fix_en  = learn_hit;
    assign fix_val = AW_W'(MAX_AW) - AW_W'(idx);
    assign fail    = (phase == PH_ADDR) && end_hi && !known && ee_do && (idx == '0);

    always_comb begin
        pins.cs = phase_selected(phase);
        pins.sk = phase_clocked(phase) && hi;
        pins.di = 1'b0;
        case (phase)
            PH_CMD:  pins.di = READ_CMD[idx[1:0]];
            PH_ADDR: pins.di = addr_q[idx[AIDX_W-1:0]];
            default: pins.di = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            hi     <= 1'b0;
            idx    <= '0;
            addr_q <= '0;
            shreg  <= '0;
            valid  <= 1'b0;
            data   <= '0;
        end else begin
            valid <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    hi <= 1'b0;
                    if (req) begin
                        addr_q <= addr;
                        phase  <= PH_SEL;
                    end
                end
                PH_SEL: begin
                    if (tick) begin
                        hi <= !hi;
                        if (hi) begin
                            phase <= PH_CMD;
                            idx   <= IDX_W'(2);
                        end
                    end
                end
                PH_CMD: begin
                    if (tick) begin
                        hi <= !hi;
                        if (hi) begin
                            if (idx == '0) begin
                                phase <= PH_ADDR;
                                idx   <= known ? (IDX_W'(width) - IDX_W'(1))
                                               : IDX_W'(MAX_AW - 1);
                            end else begin
                                idx <= idx - IDX_W'(1);
                            end
                        end
                    end
                end
                PH_ADDR: begin
                    if (tick) begin
                        hi <= !hi;
                        if (hi) begin
                            if (learn_hit || (idx == '0)) begin
                                phase <= PH_DATA;
                                idx   <= IDX_W'(DATA_W - 1);
                            end else begin
                                idx <= idx - IDX_W'(1);
                            end
                        end
                    end
                end
                PH_DATA: begin
                    if (tick) begin
                        hi <= !hi;
                        if (hi) begin
                            shreg <= {shreg[DATA_W-2:0], ee_do};
                            if (idx == '0) phase <= PH_REST;
                            else           idx   <= idx - IDX_W'(1);
                        end
                    end
                end
                PH_REST: begin
                    hi <= 1'b0;
                    if (tick) begin
                        phase <= PH_IDLE;
                        valid <= 1'b1;
                        data  <= shreg;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sprom_word_reader.sv
module sprom_word_reader
    import sprom_pkg::*;
#(
    parameter int MAX_AW = 8,
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    localparam int AW_W  = $clog2(MAX_AW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_cnt,
    input  logic              rd_req,
    input  logic [MAX_AW-1:0] rd_addr,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [AW_W-1:0]   addr_width,
    output logic              aw_err,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    logic            start;
    logic            tick;
    logic            known;
    logic            fix_en;
    logic            fail;
    logic [AW_W-1:0] fix_val;
    pins_t           pins;

    sprom_halfper #(.DIV_W(DIV_W)) u_half (
        .clk    (clk),
        .rst    (rst),
        .load   (start),
        .div_in (div_cnt),
        .run    (busy),
        .tick   (tick)
    );

    sprom_width_track #(.MAX_AW(MAX_AW), .AW_W(AW_W)) u_width (
        .clk     (clk),
        .rst     (rst),
        .fix_en  (fix_en),
        .fix_val (fix_val),
        .fail    (fail),
        .width   (addr_width),
        .known   (known),
        .err     (aw_err)
    );

    sprom_seq #(.MAX_AW(MAX_AW), .DATA_W(DATA_W), .AW_W(AW_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (rd_req),
        .addr    (rd_addr),
        .tick    (tick),
        .known   (known),
        .width   (addr_width),
        .ee_do   (ee_do),
        .start   (start),
        .busy    (busy),
        .pins    (pins),
        .fix_en  (fix_en),
        .fix_val (fix_val),
        .fail    (fail),
        .valid   (rd_valid),
        .data    (rd_data)
    );

    assign ee_cs = pins.cs;
    assign ee_sk = pins.sk;
    assign ee_di = pins.di;
endmodule

// File: rtl/sprom_reader_chk.sv
module sprom_reader_chk #(
    parameter int MAX_AW = 8,
    parameter int AW_W   = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            rd_valid,
    input logic            ee_cs,
    input logic            ee_sk,
    input logic            ee_di,
    input logic [AW_W-1:0] addr_width,
    input logic            aw_err
);
    p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ee_cs && !ee_sk));

    p_di_held_hi_r2: assert property (@(posedge clk) disable iff (rst)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    p_err_full_width_r6: assert property (@(posedge clk) disable iff (rst)
        aw_err |-> (addr_width == AW_W'(MAX_AW)));

    p_width_kept_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(addr_width) != '0) |-> $stable(addr_width));

    p_valid_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && !busy) |-> rd_valid);

    p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !busy);

    p_sk_needs_cs_r9: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> ee_cs);
endmodule

bind sprom_word_reader sprom_reader_chk #(.MAX_AW(MAX_AW), .AW_W(AW_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .ee_cs      (ee_cs),
    .ee_sk      (ee_sk),
    .ee_di      (ee_di),
    .addr_width (addr_width),
    .aw_err     (aw_err)
);

// File: tb/tb_sprom_word_reader.sv
module tb_sprom_word_reader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  div_cnt = 8'd1;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_addr = 8'd0;
    logic        busy, rd_valid, aw_err, ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b1;
    logic [15:0] rd_data;
    logic [3:0]  addr_width;

    always #2 clk = ~clk;

    sprom_word_reader dut (
        .clk(clk), .rst(rst), .div_cnt(div_cnt), .rd_req(rd_req), .rd_addr(rd_addr),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .addr_width(addr_width),
        .aw_err(aw_err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] dev_word(input logic [7:0] a);
        return {a ^ 8'hA6, ~a ^ 8'h3D};
    endfunction

    // EEPROM model; dev_aw == 0 models a device that never drives its output low.
    int          dev_aw = 6;
    bit          started;
    int          mcnt, pre, pulses;
    logic [1:0]  op_rx;
    logic [7:0]  arx;
    logic [15:0] mword;

    always @(posedge ee_sk or posedge ee_cs) begin
        if (!ee_sk) begin
            started = 0; mcnt = 0; pre = 0; pulses = 0;
            op_rx = 2'b00; arx = 8'h00; ee_do = 1'b1;
        end else begin
            pulses++;
            if (!started) begin
                if (ee_di) started = 1;
                else pre++;
            end else if (mcnt < 2) begin
                op_rx = {op_rx[0], ee_di};
                mcnt++;
            end else if (dev_aw != 0 && mcnt < 2 + dev_aw) begin
                arx = {arx[6:0], ee_di};
                mcnt++;
                if (mcnt == 2 + dev_aw) begin
                    ee_do = 1'b0;
                    mword = dev_word(arx);
                end
            end else if (dev_aw != 0 && (mcnt - 2 - dev_aw) < 16) begin
                ee_do = mword[15 - (mcnt - 2 - dev_aw)];
                mcnt++;
            end
        end
    end

    // Half-period and rest-window monitor.
    int hi_run = 0;
    int mn = 255;
    int mx = 0;
    int rest_n = 0;
    always @(negedge clk) begin
        if (ee_sk) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run < mn) mn = hi_run;
            if (hi_run > mx) mx = hi_run;
            hi_run = 0;
        end
        if (busy && !ee_cs) rest_n++;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements) actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic apply_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [7:0] dv, output logic [15:0] d);
        int w;
        mn = 255; mx = 0; rest_n = 0; hi_run = 0;
        @(negedge clk);
        div_cnt = dv; rd_addr = a; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        w = 0;
        while (!rd_valid && w < 6000) begin
            @(negedge clk);
            w++;
        end
        chk(w < 6000, "R8 valid strobe seen", w, 0);
        d = rd_data;
    endtask

    typedef struct packed {
        logic       do_rst;
        logic [3:0] dev;
        logic [7:0] dv;
        logic [7:0] addr;
        logic [3:0] ew;
        logic       eerr;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{1'b1, 4'd6, 8'd1, 8'hB4, 4'd6, 1'b0},
        '{1'b0, 4'd6, 8'd1, 8'h13, 4'd6, 1'b0},
        '{1'b0, 4'd6, 8'd3, 8'hFF, 4'd6, 1'b0},
        '{1'b1, 4'd8, 8'd2, 8'h00, 4'd8, 1'b0},
        '{1'b0, 4'd8, 8'd0, 8'hA7, 4'd8, 1'b0},
        '{1'b1, 4'd0, 8'd1, 8'h5A, 4'd8, 1'b1},
        '{1'b0, 4'd0, 8'd2, 8'h01, 4'd8, 1'b1},
        '{1'b1, 4'd4, 8'd5, 8'hC3, 4'd4, 1'b0},
        '{1'b1, 4'd1, 8'd1, 8'h80, 4'd1, 1'b0}
    };

    initial begin
        logic [15:0] got;
        apply_reset();
        @(negedge clk);
        // R1: reset state
        chk(!busy && !rd_valid, "R1 busy/valid after reset", {busy, rd_valid}, 0);
        chk(!ee_cs && !ee_sk, "R1 pins idle after reset", {ee_cs, ee_sk}, 0);
        chk(addr_width == 0 && !aw_err, "R1 width unknown after reset", {aw_err, addr_width}, 0);

        for (int i = 0; i < 9; i++) begin
            vec_t v;
            int lim;
            int dw;
            logic [7:0] da;
            logic [15:0] exp_d;
            v = VECS[i];
            if (v.do_rst) begin
                dev_aw = int'(v.dev);
                apply_reset();
            end
            dw  = int'(v.dev);
            lim = (v.dv == 0) ? 1 : int'(v.dv);
            if (dw == 0) da = 8'h00;
            else if (v.do_rst) da = v.addr >> (8 - dw);
            else da = v.addr & ((8'h01 << dw) - 8'h01);
            exp_d = (dw == 0) ? 16'hFFFF : dev_word(da);
            do_read(v.addr, v.dv, got);
            chk(got == exp_d, "R8 read data", got, exp_d);
            chk(addr_width == v.ew, v.do_rst ? "R5 learned width" : "R7 width kept", addr_width, v.ew);
            chk(aw_err == v.eerr, "R6 width error flag", aw_err, v.eerr);
            chk(pre == 1 && op_rx == 2'b10, "R2 lead pulse and read command", {pre[7:0], 6'b0, op_rx}, 16'h0102);
            chk(pulses == 20 + int'(v.ew), "R4 serial clock pulse count", pulses, 20 + int'(v.ew));
            if (dw != 0)
                chk(arx == da, v.do_rst ? "R5 address bits from top" : "R4 address bits", arx, da);
            chk(mn == lim && mx == lim, "R3 high half length", {mn[15:0], mx[15:0]}, {lim[15:0], lim[15:0]});
            chk(rest_n == lim, "R9 rest window", rest_n, lim);
        end

        // R10: request during an access is ignored (device width 1 learned above).
        begin
            int extra;
            logic [7:0] d0;
            d0 = 8'h81;
            mn = 255; mx = 0; rest_n = 0;
            @(negedge clk);
            div_cnt = 8'd2; rd_addr = d0; rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0; rd_addr = 8'h00;
            repeat (10) @(negedge clk);
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
            extra = 0;
            while (!rd_valid && extra < 6000) begin
                @(negedge clk);
                extra++;
            end
            chk(rd_data == dev_word(8'h01), "R10 data unaffected by late request", rd_data, dev_word(8'h01));
            extra = 0;
            repeat (30) begin
                @(negedge clk);
                if (ee_cs || busy) extra++;
            end
            chk(extra == 0, "R10 no access started by late request", extra, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule